// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block gathers 128 level-sensitive interrupt request lines and presents a single interrupt output to a processor. Software reaches it through a 32-bit register port: address, write data, write enable, and read data that reflects the addressed register in the same cycle. The sources are grouped into four banks of 32. Source `n` lives in bank `n >> 5` at bit `n & 31`. Each bank has write-one-to-set and write-one-to-clear registers for its mask and for a software-raise vector.

When no source is latched, the controller picks the lowest-numbered pending source that is unmasked and passes the threshold. It latches that number and raises `irq_out`. The number and the output stay frozen until software writes the acknowledge bit. On the next clock after the acknowledge, arbitration runs again.

A soft reset, started from the configuration register, restores every register to its reset value. It reports completion through a status bit four cycles later. A read-only identification register carries the major and minor revision.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the following hold:
  - every source is masked, and every mask bank reads 0xFFFFFFFF;
  - all software-raise bits read 0;
  - the threshold reads 0xFF;
  - `irq_out` is 0;
  - the status register (0x14) reads 1 in bit 0.
- R2: Mask banks work as follows:
  - writing a bank's mask-clear register (0x88 + 0x20*b) unmasks only the sources whose bits are written 1;
  - writing its mask-set register (0x8C + 0x20*b) masks only those sources;
  - both offsets read back the bank's current mask, with 1 meaning masked.
- R3: Software-raise banks work as follows:
  - writing the raise-set register (0x90 + 0x20*b) makes the sources at bits written 1 pending even with their lines low;
  - the raise-clear register (0x94 + 0x20*b) removes them;
  - both offsets read back the bank's current raise vector.
- R4: Inputs are level-sensitive. A source is pending only while its line or its raise bit is 1. A line that is low, or masked, when arbitration runs is not reported.
- R5: With no source latched, one clock edge after the winner is pending:
  - `irq_out` becomes 1;
  - the active register (0x40) reads the winner in bits [6:0] with bits [31:7] zero;
  - the winner is the lowest-numbered eligible source.
- R6: While a source is latched, the following hold until an acknowledge:
  - `irq_out` stays 1;
  - the reported number stays unchanged, even if its line falls or a lower-numbered source becomes pending.
- R7: The acknowledge works as follows:
  - writing 1 to bit 0 of the control register (0x48) clears the latch, so `irq_out` reads 0 after that edge;
  - on the following edge, arbitration runs again on the current pending set.
- R8: With nothing latched, the active register reads 0xFFFFFF80 (the spurious indication: bits [31:7] nonzero).
- R9: The threshold register (0x68) holds 8 bits. With value T other than 0xFF, only sources numbered below T are eligible. 0xFF makes every unmasked source eligible.
- R10: The soft reset works as follows:
  - writing 1 to bit 1 of the configuration register (0x10) restores all R1 values;
  - status bit 0 reads 0 for the four cycles after that write, then reads 1 again.
- R11: While the soft reset is in progress, writes to any register other than 0x10 have no effect.
- R12: The identification register (0x00) reads the major revision in bits [7:4] and the minor revision in bits [3:0], with upper bits zero. The defaults give 0x21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_lines | input | 128 | Level-sensitive interrupt request lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is arbitration over a known, complete pending set. Because the latch freezes on the first edge any source is eligible, a configuration written bank by bank would latch a partial winner. The stimulus therefore masks everything and acknowledges first. It then writes the random masks and threshold while all lines are low, and drives the random line pattern in a single step. The expected winner is then computed over exactly that set. Directed sequences cover the cases that only arise while the latch is held or the soft reset is running: a lower source arriving and the latched line falling, and writes issued inside the reset window.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int BANK_W      = 32;
    localparam int BANK_STRIDE = 32'h20;

    localparam int OFF_IDENT    = 32'h00;
    localparam int OFF_CFG      = 32'h10;
    localparam int OFF_STATUS   = 32'h14;
    localparam int OFF_ACTIVE   = 32'h40;
    localparam int OFF_CTRL     = 32'h48;
    localparam int OFF_THRESH   = 32'h68;
    localparam int OFF_MASK_CLR = 32'h88;
    localparam int OFF_MASK_SET = 32'h8C;
    localparam int OFF_RAISE_SET = 32'h90;
    localparam int OFF_RAISE_CLR = 32'h94;

    localparam logic [7:0]  THR_OPEN  = 8'hFF;
    localparam logic [31:0] SPURIOUS  = 32'hFFFF_FF80;
    localparam int          CFG_SRST_BIT = 1;
    localparam int          CTRL_ACK_BIT = 0;
endpackage

// File: rtl/intc_prio_find.sv
module intc_prio_find #(
    parameter int N     = 128,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // scan downward so the lowest set index is the last one assigned
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_soft_reset_timer.sv
module intc_soft_reset_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import intc_pkg::*;
#(
    parameter int         NUM_SRC    = 128,
    parameter int         ADDR_W     = 12,
    parameter int         RST_CYCLES = 4,
    parameter logic [3:0] REV_MAJOR  = 4'd2,
    parameter logic [3:0] REV_MINOR  = 4'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_we,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_lines,
    output logic               irq_out
);
    localparam int NUM_W    = $clog2(NUM_SRC);
    localparam int NUM_BANK = NUM_SRC / BANK_W;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] raise;
        logic [7:0]         thr;
        logic               act_valid;
        logic [NUM_W-1:0]   act_num;
    } state_t;

    localparam state_t ST_RESET = '{
        mask:      {NUM_SRC{1'b1}},
        raise:     {NUM_SRC{1'b0}},
        thr:       THR_OPEN,
        act_valid: 1'b0,
        act_num:   {NUM_W{1'b0}}
    };

    state_t st_d, st_q;

    logic               busy;
    logic               srst_start;
    logic               wr_ok;
    logic               ack_wr;
    logic [NUM_SRC-1:0] eligible;
    logic [NUM_SRC-1:0] pend;
    logic               found;
    logic [NUM_W-1:0]   win;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_W-1:0]   act_num_q;

    assign mask_q    = st_q.mask;
    assign act_num_q = st_q.act_num;

    assign srst_start = bus_we && (bus_addr == ADDR_W'(OFF_CFG)) && bus_wdata[CFG_SRST_BIT];
    assign wr_ok      = bus_we && !busy && !srst_start;
    assign ack_wr     = wr_ok && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[CTRL_ACK_BIT];

    intc_soft_reset_timer #(.CYCLES(RST_CYCLES)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (busy)
    );

    // threshold gate: a source qualifies when its number is below the level
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign eligible[i] = (st_q.thr == THR_OPEN) || ({1'b0, st_q.thr} > 9'(i));
    end

    assign pend = (irq_lines | st_q.raise) & ~st_q.mask & eligible;

    intc_prio_find #(.N(NUM_SRC), .IDX_W(NUM_W)) u_find (
        .req   (pend),
        .found (found),
        .idx   (win)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            if (bus_addr == ADDR_W'(OFF_THRESH)) st_d.thr = bus_wdata[7:0];
            for (int b = 0; b < NUM_BANK; b++) begin
                if (bus_addr == ADDR_W'(OFF_MASK_CLR + b * BANK_STRIDE))
                    st_d.mask[b*BANK_W +: BANK_W] = st_q.mask[b*BANK_W +: BANK_W] & ~bus_wdata;
                if (bus_addr == ADDR_W'(OFF_MASK_SET + b * BANK_STRIDE))
                    st_d.mask[b*BANK_W +: BANK_W] = st_q.mask[b*BANK_W +: BANK_W] | bus_wdata;
                if (bus_addr == ADDR_W'(OFF_RAISE_SET + b * BANK_STRIDE))
                    st_d.raise[b*BANK_W +: BANK_W] = st_q.raise[b*BANK_W +: BANK_W] | bus_wdata;
                if (bus_addr == ADDR_W'(OFF_RAISE_CLR + b * BANK_STRIDE))
                    st_d.raise[b*BANK_W +: BANK_W] = st_q.raise[b*BANK_W +: BANK_W] & ~bus_wdata;
            end
        end
        if (!st_q.act_valid && found) begin
            st_d.act_valid = 1'b1;
            st_d.act_num   = win;
        end
        if (ack_wr) st_d.act_valid = 1'b0;
        if (srst_start || busy) st_d = ST_RESET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_IDENT))  bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
        if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = {31'd0, !busy};
        if (bus_addr == ADDR_W'(OFF_ACTIVE))
            bus_rdata = st_q.act_valid ? {{(32-NUM_W){1'b0}}, act_num_q} : SPURIOUS;
        if (bus_addr == ADDR_W'(OFF_THRESH)) bus_rdata = {24'd0, st_q.thr};
        for (int b = 0; b < NUM_BANK; b++) begin
            if (bus_addr == ADDR_W'(OFF_MASK_CLR + b * BANK_STRIDE) ||
                bus_addr == ADDR_W'(OFF_MASK_SET + b * BANK_STRIDE))
                bus_rdata = mask_q[b*BANK_W +: BANK_W];
            if (bus_addr == ADDR_W'(OFF_RAISE_SET + b * BANK_STRIDE) ||
                bus_addr == ADDR_W'(OFF_RAISE_CLR + b * BANK_STRIDE))
                bus_rdata = st_q.raise[b*BANK_W +: BANK_W];
        end
    end

    assign irq_out = st_q.act_valid;
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 128,
    parameter int ADDR_W  = 12,
    parameter int NUM_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               bus_we,
    input logic [31:0]        bus_rdata,
    input logic               irq_out,
    input logic [NUM_W-1:0]   act_num,
    input logic [NUM_SRC-1:0] mask_cur,
    input logic               busy
);
    logic ack_wr, srst_wr;
    logic [NUM_SRC-1:0] mask_prev;

    assign ack_wr  = bus_we && (bus_addr == ADDR_W'(OFF_CTRL)) && bus_wdata[CTRL_ACK_BIT];
    assign srst_wr = bus_we && (bus_addr == ADDR_W'(OFF_CFG)) && bus_wdata[CFG_SRST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_prev <= '1;
        else        mask_prev <= mask_cur;
    end

    // R6: latched request holds, number frozen
    a_r6_hold_latched: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && !ack_wr && !srst_wr |=> irq_out && $stable(act_num));

    // R7: acknowledge drops the request for one edge
    a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && ack_wr && !busy |=> !irq_out);

    // R10: soft reset enters the busy window with no request
    a_r10_srst_busy: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> busy && !irq_out);

    // R8: idle active register reads the spurious code
    a_r8_spurious_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_ACTIVE)) && !irq_out |-> bus_rdata == SPURIOUS);

    // R5: a newly latched source was unmasked when it won
    a_r5_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> !mask_prev[act_num]);
endmodule

bind irq_vector_ctrl intc_checker #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .NUM_W   (NUM_W)
) u_intc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .act_num   (act_num_q),
    .mask_cur  (mask_q),
    .busy      (busy)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
    localparam int NSRC = 128;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] irq_lines = '0;
    logic            irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [NSRC-1:0] m_mask;
    logic [NSRC-1:0] m_raise;
    logic [7:0]      m_thr;

    always #2.5 clk = ~clk;

    irq_vector_ctrl u_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_lines(irq_lines), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_active(input logic [NSRC-1:0] lines,
        input logic [NSRC-1:0] rs, input logic [NSRC-1:0] mk, input logic [7:0] thr);
        for (int i = 0; i < NSRC; i++)
            if ((lines[i] || rs[i]) && !mk[i] && (thr == 8'hFF || i < int'(thr)))
                return 32'(i);
        return 32'hFFFF_FF80;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic ack();
        wr(12'h048, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int b = 0; b < 4; b++) begin
            rchk("R1 mask bank", 12'(32'h88 + b * 32'h20), 32'hFFFF_FFFF);
            rchk("R1 raise bank", 12'(32'h90 + b * 32'h20), 32'h0);
        end
        rchk("R1 threshold", 12'h068, 32'hFF);
        rchk("R1 status", 12'h014, 32'h1);
        chk("R1 irq_out", 32'(irq_out), 32'h0);
        rchk("R8 spurious after reset", 12'h040, 32'hFFFF_FF80);
        rchk("R12 ident", 12'h000, 32'h21);

        // R2 per-bit mask set/clear
        wr(12'h0A8, 32'h0000_0005);
        rchk("R2 clear bits bank1", 12'h0A8, 32'hFFFF_FFFA);
        wr(12'h0AC, 32'h0000_0001);
        rchk("R2 set bit bank1", 12'h0A8, 32'hFFFF_FFFB);
        rchk("R2 other bank untouched", 12'h088, 32'hFFFF_FFFF);

        // R4/R5 lowest wins
        for (int b = 0; b < 4; b++) wr(12'(32'h88 + b * 32'h20), 32'hFFFF_FFFF);
        irq_lines[70] = 1'b1; irq_lines[9] = 1'b1;
        @(negedge clk);
        rchk("R5 lowest of 9,70", 12'h040, 32'd9);
        chk("R5 irq_out", 32'(irq_out), 32'h1);

        // R6 frozen
        irq_lines[9] = 1'b0; irq_lines[2] = 1'b1;
        repeat (3) @(negedge clk);
        rchk("R6 held number", 12'h040, 32'd9);
        chk("R6 irq_out held", 32'(irq_out), 32'h1);

        // R7 ack then rearbitrate
        ack();
        chk("R7 irq low after ack", 32'(irq_out), 32'h0);
        @(negedge clk);
        rchk("R7 new winner", 12'h040, 32'd2);
        chk("R7 irq back", 32'(irq_out), 32'h1);

        // R4 dropped lines not reported, R8 spurious
        irq_lines = '0;
        ack();
        @(negedge clk);
        rchk("R4 no stale source", 12'h040, 32'hFFFF_FF80);
        chk("R8 irq idle", 32'(irq_out), 32'h0);

        // R3 software raise
        wr(12'h0F0, 32'h0000_0020);
        rchk("R3 raise readback", 12'h0F4, 32'h0000_0020);
        @(negedge clk);
        rchk("R3 raised source", 12'h040, 32'd101);
        wr(12'h0F4, 32'h0000_0020);
        ack();
        @(negedge clk);
        rchk("R3 raise cleared", 12'h040, 32'hFFFF_FF80);

        // R9 threshold
        wr(12'h068, 32'd50);
        irq_lines[60] = 1'b1; irq_lines[100] = 1'b1;
        repeat (2) @(negedge clk);
        rchk("R9 above level filtered", 12'h040, 32'hFFFF_FF80);
        irq_lines[20] = 1'b1;
        @(negedge clk);
        rchk("R9 below level passes", 12'h040, 32'd20);
        irq_lines = '0;
        ack();
        wr(12'h068, 32'hFF);
        irq_lines[100] = 1'b1;
        @(negedge clk);
        rchk("R9 open level", 12'h040, 32'd100);
        irq_lines = '0;
        ack();

        // R10 soft reset
        wr(12'h068, 32'h30);
        wr(12'h010, 32'h2);
        rchk("R10 busy c0", 12'h014, 32'h0);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            rchk("R10 busy window", 12'h014, 32'h0);
        end
        @(negedge clk);
        rchk("R10 done", 12'h014, 32'h1);
        rchk("R10 mask restored", 12'h088, 32'hFFFF_FFFF);
        rchk("R10 threshold restored", 12'h068, 32'hFF);

        // R11 writes ignored during reset window
        wr(12'h010, 32'h2);
        wr(12'h088, 32'hFFFF_FFFF);
        wr(12'h068, 32'h05);
        wr(12'h0B0, 32'h1);
        repeat (4) @(negedge clk);
        rchk("R11 mask write ignored", 12'h088, 32'hFFFF_FFFF);
        rchk("R11 threshold write ignored", 12'h068, 32'hFF);
        rchk("R11 raise write ignored", 12'h0B0, 32'h0);
        wr(12'h088, 32'h1);
        rchk("R11 write accepted after", 12'h088, 32'hFFFF_FFFE);

        // R5/R9/R2 random arbitration
        for (int it = 0; it < 60; it++) begin
            logic [31:0] clr [4];
            irq_lines = '0;
            for (int b = 0; b < 4; b++) wr(12'(32'h8C + b * 32'h20), 32'hFFFF_FFFF);
            ack();
            m_thr = ($urandom % 4 == 0) ? 8'($urandom % 128) : 8'hFF;
            wr(12'h068, 32'(m_thr));
            for (int b = 0; b < 4; b++) begin
                clr[b] = $urandom;
                wr(12'(32'h88 + b * 32'h20), clr[b]);
            end
            m_mask  = ~{clr[3], clr[2], clr[1], clr[0]};
            m_raise = '0;
            irq_lines = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
                         $urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
            @(negedge clk);
            v = exp_active(irq_lines, m_raise, m_mask, m_thr);
            rchk("R5 random winner", 12'h040, v);
            chk("R5 random irq_out", 32'(irq_out), (v == 32'hFFFF_FF80) ? 32'h0 : 32'h1);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule